// File: doc/BRIEF.md
# Rotation Slice Timing Generator

This block turns the pulses of an optical gap sensor on a spinning LED panel into angular slice timing. Several marks sit around the fixed part of the machine. The block filters the raw sensor level and takes each clean rising edge as a mark. It counts the clock cycles between successive marks. It then splits the next interval into equal slice ticks, so that every revolution yields a fixed number of slices (256 by default).

For each tick the block raises a one-cycle strobe. With the strobe it gives the slice index and the base address of that slice's row in a frame buffer. A row holds the colour entries for a 40×30 panel, 1200 entries. Slices are consumed in order, so slice n addresses row n.

The first mark after reset, or after a loss of rotation, becomes the index mark, which is slice 0. The period used for a mark segment is the interval just measured. A fractional accumulator spreads the remainder of that period over the segment, so no error carries to the next mark. Any new mark immediately realigns the slice count.

Top module: `slice_timer`

## Requirements
- R1: The sensor input is synchronized and debounced. A level must hold for DEB_LEN consecutive cycles before it is accepted, so shorter pulses have no effect on the slice timing. Only an accepted rising level counts as a mark, and falling edges are ignored.
- R2: `slice_valid` is 0 until 2×MARKS mark intervals have been measured after the first mark. It becomes 1 at the mark that completes them.
- R3: `slice_strobe` pulses only while `slice_valid` is 1. Within a revolution, successive strobes carry `slice_idx` values that rise by exactly one, modulo SLICES.
- R4: When a mark interval P equals the one before it, the segment gives exactly SLICES/MARKS strobes. Successive strobes are floor(P/(SLICES/MARKS)) or ceil(P/(SLICES/MARKS)) cycles apart. A revolution of four equal intervals gives SLICES strobes.
- R5: The first mark after reset or timeout is the index mark. Mark k after it (counted modulo MARKS) produces a strobe at once with `slice_idx` = k×SLICES/MARKS. The first strobe after `slice_valid` rises has index 0.
- R6: If a mark arrives before all slices of the current segment are issued, the remaining slices are skipped. The next strobe carries the first index of the following segment.
- R7: Once a segment has issued all its slices, the block issues no further strobe until the next mark.
- R8: If no mark arrives for TIMEOUT cycles, `slice_valid` drops to 0, strobes stop, and learning restarts as after reset.
- R9: `row_base` always equals `slice_idx` × ROW_WORDS.
- R10: While reset is asserted, `slice_strobe`, `slice_valid`, `slice_idx` and `row_base` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sensor_in | input | 1 | Raw photosensor level, high while a mark is in the gap |
| slice_strobe | output | 1 | One-cycle pulse at the start of each slice |
| slice_idx | output | $clog2(SLICES) | Index of the current slice |
| row_base | output | $clog2(SLICES×ROW_WORDS) | First frame-buffer address of the current slice row |
| slice_valid | output | 1 | Timing is locked to the rotation |

## Verification
The checker takes for granted that the sensor only gives clean marks. Each mark must stay high for well over DEB_LEN cycles, and marks must be spaced far wider than a segment's slice count, so that every segment has room for its ticks. It also assumes the spacing is shorter than TIMEOUT, except where rotation stops on purpose. The only short pulse the stimulus produces is a deliberate glitch shorter than the debounce window. The bench holds each mark high for 40 cycles and uses intervals of 500 to 1024 cycles. It stops the marks only to test the timeout.

// File: rtl/slice_pkg.sv
package slice_pkg;
  // Angular resolution of one revolution.
  localparam int unsigned SLICES_PER_REV = 256;
  // Colour entries in one slice row (40 x 30 panel).
  localparam int unsigned ROW_ENTRIES    = 1200;
endpackage

// File: rtl/sensor_cond.sv
module sensor_cond #(
  parameter int unsigned DEB_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic mark_p
);
  localparam int unsigned CW = $clog2(DEB_LEN + 1);

  logic          s1_q, s2_q, lvl_q, lvl_n, mark_q, mark_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          differ, flip;

  always_comb begin
    differ = s2_q ^ lvl_q;
    flip   = differ && (cnt_q == CW'(DEB_LEN - 1));
    cnt_n  = (differ && !flip) ? cnt_q + 1'b1 : '0;
    lvl_n  = flip ? s2_q : lvl_q;
    mark_n = flip && s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
      mark_q <= 1'b0;
    end else begin
      s1_q   <= raw_in;
      s2_q   <= s1_q;
      lvl_q  <= lvl_n;
      cnt_q  <= cnt_n;
      mark_q <= mark_n;
    end
  end

  assign mark_p = mark_q;
endmodule

// File: rtl/interval_meter.sv
module interval_meter #(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned MARKS   = 4,
  parameter int unsigned TIMEOUT = 8000000,
  parameter int unsigned SEG_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark,
  output logic [CNT_W-1:0] period,
  output logic [SEG_W-1:0] seg,
  output logic             valid
);
  localparam int unsigned LEARN = 2 * MARKS + 1;
  localparam int unsigned LW    = $clog2(LEARN + 1);

  logic [CNT_W-1:0] ivl_q, ivl_n, per_q, per_n;
  logic [SEG_W-1:0] seg_q, seg_n;
  logic [LW-1:0]    seen_q, seen_n;
  logic             val_q, val_n, first;

  always_comb begin
    ivl_n  = ivl_q;
    per_n  = per_q;
    seg_n  = seg_q;
    seen_n = seen_q;
    val_n  = val_q;
    first  = (seen_q == '0);
    if (mark) begin
      ivl_n  = CNT_W'(1);
      per_n  = first ? per_q : ivl_q;
      seg_n  = (first || seg_q == SEG_W'(MARKS - 1)) ? '0 : seg_q + 1'b1;
      seen_n = (seen_q == LW'(LEARN)) ? seen_q : seen_q + 1'b1;
      val_n  = (seen_n == LW'(LEARN));
    end else if (ivl_q >= CNT_W'(TIMEOUT)) begin
      seen_n = '0;
      val_n  = 1'b0;
    end else begin
      ivl_n  = ivl_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q  <= '0;
      per_q  <= '0;
      seg_q  <= '0;
      seen_q <= '0;
      val_q  <= 1'b0;
    end else begin
      ivl_q  <= ivl_n;
      per_q  <= per_n;
      seg_q  <= seg_n;
      seen_q <= seen_n;
      val_q  <= val_n;
    end
  end

  assign period = per_q;
  assign seg    = seg_q;
  assign valid  = val_q;
endmodule

// File: rtl/slice_gen.sv
module slice_gen #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned SPM   = 64,
  parameter int unsigned SUB_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark,
  input  logic [CNT_W-1:0] period,
  output logic [SUB_W-1:0] sub,
  output logic             tick
);
  logic [CNT_W:0]   acc_q, acc_n, sum;
  logic [SUB_W-1:0] sub_q, sub_n;
  logic             tick_q, tick_n;

  always_comb begin
    sum    = acc_q + (CNT_W+1)'(SPM);
    acc_n  = acc_q;
    sub_n  = sub_q;
    tick_n = 1'b0;
    if (mark) begin
      acc_n  = '0;
      sub_n  = '0;
      tick_n = 1'b1;
    end else if (sub_q != SUB_W'(SPM - 1)) begin
      if (sum >= {1'b0, period}) begin
        acc_n  = sum - {1'b0, period};
        sub_n  = sub_q + 1'b1;
        tick_n = 1'b1;
      end else begin
        acc_n  = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      sub_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_n;
      sub_q  <= sub_n;
      tick_q <= tick_n;
    end
  end

  assign sub  = sub_q;
  assign tick = tick_q;
endmodule

// File: rtl/slice_timer.sv
module slice_timer
  import slice_pkg::*;
#(
  parameter int unsigned SLICES    = SLICES_PER_REV,
  parameter int unsigned MARKS     = 4,
  parameter int unsigned ROW_WORDS = ROW_ENTRIES,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned DEB_LEN   = 4,
  parameter int unsigned TIMEOUT   = 8000000,
  localparam int unsigned IDX_W    = $clog2(SLICES),
  localparam int unsigned ADDR_W   = $clog2(SLICES * ROW_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sensor_in,
  output logic              slice_strobe,
  output logic [IDX_W-1:0]  slice_idx,
  output logic [ADDR_W-1:0] row_base,
  output logic              slice_valid
);
  localparam int unsigned SPM   = SLICES / MARKS;
  localparam int unsigned SUB_W = $clog2(SPM);
  localparam int unsigned SEG_W = (MARKS > 1) ? $clog2(MARKS) : 1;

  logic             rs1_q, rst_q_n, mark_p, tick, valid;
  logic [CNT_W-1:0] period;
  logic [SEG_W-1:0] seg;
  logic [SUB_W-1:0] sub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q   <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rs1_q   <= 1'b1;
      rst_q_n <= rs1_q;
    end
  end

  sensor_cond #(.DEB_LEN(DEB_LEN)) u_cond (
    .clk(clk), .rst_n(rst_q_n), .raw_in(sensor_in), .mark_p(mark_p)
  );

  interval_meter #(
    .CNT_W(CNT_W), .MARKS(MARKS), .TIMEOUT(TIMEOUT), .SEG_W(SEG_W)
  ) u_meter (
    .clk(clk), .rst_n(rst_q_n), .mark(mark_p),
    .period(period), .seg(seg), .valid(valid)
  );

  slice_gen #(.CNT_W(CNT_W), .SPM(SPM), .SUB_W(SUB_W)) u_gen (
    .clk(clk), .rst_n(rst_q_n), .mark(mark_p), .period(period),
    .sub(sub), .tick(tick)
  );

  generate
    if (MARKS > 1) begin : g_multi
      assign slice_idx = {seg[SEG_W-1:0], sub};
    end else begin : g_single
      logic unused_seg;
      assign unused_seg = ^seg;
      assign slice_idx  = sub;
    end
  endgenerate

  assign slice_strobe = tick & valid;
  assign slice_valid  = valid;
  assign row_base     = ADDR_W'(slice_idx) * ADDR_W'(ROW_WORDS);
endmodule

// File: rtl/slice_timer_chk.sv
module slice_timer_chk #(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned SUB_W   = 6,
  parameter int unsigned TIMEOUT = 8000000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mark,
  input logic             strobe,
  input logic [IDX_W-1:0] idx,
  input logic             valid
);
  localparam int unsigned IW = $clog2(TIMEOUT + 8) + 1;

  logic [IDX_W-1:0] last_idx;
  logic [IW-1:0]    idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx <= '0;
      idle     <= '0;
    end else begin
      if (strobe) last_idx <= idx;
      if (mark) idle <= '0;
      else if (idle != {IW{1'b1}}) idle <= idle + 1'b1;
    end
  end

  AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> valid); // R3

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && idx[SUB_W-1:0] != '0) |-> idx == IDX_W'(last_idx + 1'b1)); // R3

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && !strobe) |-> $stable(idx)); // R7

  AST_LOCK_AT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> (strobe && idx == '0)); // R2

  AST_MARK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mark |=> (!valid || (strobe && idx[SUB_W-1:0] == '0))); // R6

  AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (idle > IW'(TIMEOUT + 2)) |-> !valid); // R8
endmodule

bind slice_timer slice_timer_chk #(
  .IDX_W(IDX_W), .SUB_W(SUB_W), .TIMEOUT(TIMEOUT)
) u_chk (
  .clk(clk), .rst_n(rst_q_n), .mark(mark_p), .strobe(slice_strobe),
  .idx(slice_idx), .valid(slice_valid)
);

// File: tb/slice_timer_tb.sv
module slice_timer_tb;
  localparam int SL = 256, MK = 4, RW = 1200, TO = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sensor = 1'b0;
  logic        slice_strobe, slice_valid;
  logic [7:0]  slice_idx;
  logic [18:0] row_base;

  int checks = 0, failures = 0;
  int cyc = 0;
  int strobe_n, gap_min, gap_max, seq_err, base_err, first_idx, last_idx, last_t;
  bit have_last;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  slice_timer #(
    .SLICES(SL), .MARKS(MK), .ROW_WORDS(RW), .CNT_W(16), .DEB_LEN(4), .TIMEOUT(TO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sensor_in(sensor), .slice_strobe(slice_strobe),
    .slice_idx(slice_idx), .row_base(row_base), .slice_valid(slice_valid)
  );

  always @(negedge clk) begin
    if (slice_strobe) begin
      if (strobe_n == 0) first_idx = int'(slice_idx);
      if (have_last) begin
        if (cyc - last_t < gap_min) gap_min = cyc - last_t;
        if (cyc - last_t > gap_max) gap_max = cyc - last_t;
        if (int'(slice_idx) != (last_idx + 1) % SL) seq_err++;
      end
      if (int'(row_base) != int'(slice_idx) * RW) base_err++;
      have_last = 1'b1;
      last_idx  = int'(slice_idx);
      last_t    = cyc;
      strobe_n++;
    end
  end

  task automatic clr();
    strobe_n = 0; gap_min = 1 << 30; gap_max = 0; seq_err = 0;
    base_err = 0; first_idx = -1; have_last = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_marks(input int n, input int p);
    repeat (n) begin
      sensor = 1'b1;
      repeat (40) @(negedge clk);
      sensor = 1'b0;
      repeat (p - 40) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    clr();
    repeat (5) @(negedge clk);
    check(!slice_strobe && !slice_valid && slice_idx == 0 && row_base == 0,
          "R10 reset outputs", int'(slice_valid), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(!slice_valid, "R10 idle after reset", int'(slice_valid), 0);
  endtask

  task automatic t_learn();
    clr();
    run_marks(8, 1024);
    check(!slice_valid, "R2 not valid before two revolutions", int'(slice_valid), 0);
    check(strobe_n == 0, "R3 no strobe while invalid", strobe_n, 0);
    run_marks(4, 1024);
    check(slice_valid, "R2 valid after two revolutions", int'(slice_valid), 1);
    check(first_idx == 0, "R5 first slice is index 0", first_idx, 0);
    check(strobe_n == SL, "R4 slices per revolution", strobe_n, SL);
    check(gap_min == 16 && gap_max == 16, "R4 even spacing", gap_max, 16);
    check(seq_err == 0, "R3 sequential index", seq_err, 0);
    check(base_err == 0, "R9 row base", base_err, 0);
  endtask

  task automatic t_frac();
    run_marks(4, 1000);
    clr();
    run_marks(4, 1000);
    check(strobe_n == SL, "R4 fractional slices per revolution", strobe_n, SL);
    check(gap_min == 15 && gap_max == 16, "R4 fractional spacing", gap_min, 15);
    check(seq_err == 0, "R3 fractional order", seq_err, 0);
    check(first_idx % 64 == 0, "R5 mark aligns segment start", first_idx % 64, 0);
  endtask

  task automatic t_early();
    int prev_last;
    clr();
    run_marks(1, 500);
    check(strobe_n == 32, "R6 slices before early mark", strobe_n, 32);
    check(last_idx % 64 == 31, "R6 last slice before early mark", last_idx % 64, 31);
    prev_last = last_idx;
    clr();
    run_marks(1, 1000);
    check(first_idx == ((prev_last / 64 + 1) * 64) % SL, "R6 realign after skip",
          first_idx, ((prev_last / 64 + 1) * 64) % SL);
    check(strobe_n == 64, "R7 no extra slices in long segment", strobe_n, 64);
  endtask

  task automatic t_glitch();
    run_marks(4, 1000);
    clr();
    repeat (4) begin
      sensor = 1'b1;
      repeat (40) @(negedge clk);
      sensor = 1'b0;
      repeat (400) @(negedge clk);
      sensor = 1'b1;
      repeat (2) @(negedge clk);
      sensor = 1'b0;
      repeat (558) @(negedge clk);
    end
    check(strobe_n == SL, "R1 glitch ignored count", strobe_n, SL);
    check(gap_min == 15 && gap_max == 16, "R1 glitch ignored spacing", gap_max, 16);
    check(seq_err == 0, "R1 glitch ignored order", seq_err, 0);
  endtask

  task automatic t_timeout();
    repeat (2000) @(negedge clk);
    check(slice_valid, "R8 valid before timeout", int'(slice_valid), 1);
    repeat (3000) @(negedge clk);
    check(!slice_valid, "R8 valid drops on timeout", int'(slice_valid), 0);
    clr();
    repeat (300) @(negedge clk);
    check(strobe_n == 0, "R8 strobes stop", strobe_n, 0);
    run_marks(8, 1024);
    check(!slice_valid, "R8 relearn needed", int'(slice_valid), 0);
    check(strobe_n == 0, "R8 silent while relearning", strobe_n, 0);
    run_marks(1, 1024);
    check(slice_valid, "R2 valid again", int'(slice_valid), 1);
    check(first_idx == 0 && strobe_n == 64, "R5 new index mark", first_idx, 0);
  endtask

  initial begin
    t_reset();
    t_learn();
    t_frac();
    t_early();
    t_glitch();
    t_timeout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule